// File: doc/BRIEF.md
# Multi-Slave Tuning Word Serial Master

This block drives a shared two-wire serial link (clock plus data) that programs several digitally tunable capacitor slaves. Each slave has its own enable wire, which works as a chip select. A host issues one request with a slave index, a 5-bit capacitance state and a standby flag. The master then raises that slave's enable, shifts out an 8-bit word most significant bit first, and lowers the enable. The slave applies the new state when its enable goes low.

Each request drives only one enable line, so slaves change state one after another in request order. Every serial edge is placed by counters in system clock cycles. These counts come from minimum times in picoseconds, rounded up. The link therefore meets the slaves' limits on enable-to-clock setup, data setup and hold, clock-to-enable hold, enable-low gap and maximum serial clock rate. A busy flag and a one-cycle done pulse give the handshake. A request with an index outside the slave range returns a one-cycle error pulse.

Top module: `dtc_prog_master`

## Requirements
- R1: During and after reset, `sclk`, every `sen` bit, `busy`, `done` and `err` are low.
- R2: In each transaction exactly 8 rising edges of `sclk` occur. The `sdata` values sampled at those edges are {0, 0, standby, state[4:0]}, bit 7 first.
- R3: An accepted request with index k sets `sen` bit k and only that bit. No other enable bit rises during the transaction.
- R4: `sdata` never changes in a cycle in which `sclk` is high. It changes only in the cycle where `sclk` falls, or while `sclk` stays low.
- R5: Each `sclk` high phase and each low phase between bits lasts at least the data setup/hold minimum (13.2 ns at defaults). The interval between rising edges is at least the 26 MHz period.
- R6: The first `sclk` rise comes at least 19.2 ns after the enable rises, and no earlier than the data setup time. The enable falls at least 19.2 ns after the last `sclk` rise. `sclk` is low whenever no enable is high.
- R7: `done` is high for exactly one cycle: the first cycle in which the target enable is low again.
- R8: `busy` is high from the cycle after acceptance until at least 38.4 ns after the enable falls. A request presented while `busy` is high is ignored.
- R9: A request with index not below the slave count raises `err` for one cycle. No enable is driven and `busy` stays low.
- R10: Between two transactions all enables stay low for at least 38.4 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_idx | input | IDX_W | Target slave index |
| req_state | input | 5 | Capacitance state code |
| req_stby | input | 1 | Standby flag placed in word bit 5 |
| busy | output | 1 | Transaction or enable-low gap in progress |
| done | output | 1 | One-cycle pulse when the enable falls |
| err | output | 1 | One-cycle pulse for an out-of-range index |
| sclk | output | 1 | Shared serial clock, idles low |
| sdata | output | 1 | Shared serial data |
| sen | output | NUM_SLV | Per-slave enable lines, idle low |

## Verification
The hardest case to reach is a request that arrives while the master is mid-transfer with a different index. It must leave the active enable alone and start nothing after the transfer ends. The bench reaches it by pulsing a stray request a few cycles into a transfer. It then watches the enables and `busy` for several cycles after completion. Back-to-back requests at every index, state and standby value exercise the enable-low gap and the word layout. Indices past the slave range exercise the rejection path.

// File: rtl/dtcp_pkg.sv
package dtcp_pkg;
  localparam int WORD_W  = 8;
  localparam int STATE_W = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEAD, PH_HIGH, PH_LOW, PH_TRAIL, PH_GAP
  } phase_e;

  function automatic logic [WORD_W-1:0] pack_word(input logic stby,
                                                   input logic [STATE_W-1:0] st);
    return {2'b00, stby, st};
  endfunction

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dtcp_phase_timer.sv
module dtcp_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dtcp_shift_out.sv
module dtcp_shift_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         bit_out,
  output logic         last_bit
);
  localparam int BC_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]    sh;
  logic [BC_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= word;
      left <= BC_W'(W - 1);
    end else if (shift) begin
      sh   <= {sh[W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign bit_out  = sh[W-1];
  assign last_bit = (left == '0);

  // R2: never shift beyond the final bit of a word
  p_no_overshift_r2: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |-> !last_bit);
endmodule

// File: rtl/dtcp_sel_decode.sv
module dtcp_sel_decode #(
  parameter int NUM_SLV = 4,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   idx,
  input  logic               set,
  input  logic               clr,
  output logic               idx_ok,
  output logic [NUM_SLV-1:0] sel
);
  assign idx_ok = (int'(idx) < NUM_SLV);

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)                               sel[i] <= 1'b0;
      else if (clr)                          sel[i] <= 1'b0;
      else if (set && (int'(idx) == i))      sel[i] <= 1'b1;
    end
  end

  // R3: at most one enable line is ever active
  p_single_sel_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: rtl/dtc_prog_master.sv
module dtc_prog_master
  import dtcp_pkg::*;
#(
  parameter int NUM_SLV      = 4,
  parameter int IDX_W        = 3,
  parameter int CLK_PS       = 20000,
  parameter int SETUP_PS     = 19200,
  parameter int HOLD_PS      = 19200,
  parameter int DATA_PS      = 13200,
  parameter int GAP_PS       = 38400,
  parameter int MIN_PER_PS   = 38462,
  parameter int CNT_W        = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [4:0]         req_state,
  input  logic               req_stby,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               sclk,
  output logic               sdata,
  output logic [NUM_SLV-1:0] sen
);
  localparam int HALF_CYC  = max2(1, max2(ceil_div(DATA_PS, CLK_PS),
                                          ceil_div(MIN_PER_PS, 2 * CLK_PS)));
  localparam int LEAD_CYC  = max2(1, max2(ceil_div(SETUP_PS, CLK_PS),
                                          ceil_div(DATA_PS, CLK_PS)));
  localparam int TRAIL_CYC = max2(1, ceil_div(HOLD_PS, CLK_PS) - HALF_CYC);
  localparam int GAP_CYC   = max2(1, ceil_div(GAP_PS, CLK_PS));

  phase_e           ph;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             idx_ok;
  logic             accept;
  logic             reject;
  logic             do_shift;
  logic             last_bit;
  logic             sel_clr;
  logic             sclk_q;
  logic             busy_q;
  logic             done_q;
  logic             err_q;

  assign accept   = (ph == PH_IDLE) && req_valid && idx_ok;
  assign reject   = (ph == PH_IDLE) && req_valid && !idx_ok;
  assign do_shift = (ph == PH_HIGH) && tmr_zero && !last_bit;
  assign sel_clr  = (ph == PH_TRAIL) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (ph)
      PH_IDLE:  if (accept)   begin tmr_load = 1'b1; tmr_val = CNT_W'(LEAD_CYC - 1); end
      PH_LEAD:  if (tmr_zero) begin tmr_load = 1'b1; tmr_val = CNT_W'(HALF_CYC - 1); end
      PH_HIGH:  if (tmr_zero) begin
                  tmr_load = 1'b1;
                  tmr_val  = last_bit ? CNT_W'(TRAIL_CYC - 1) : CNT_W'(HALF_CYC - 1);
                end
      PH_LOW:   if (tmr_zero) begin tmr_load = 1'b1; tmr_val = CNT_W'(HALF_CYC - 1); end
      PH_TRAIL: if (tmr_zero) begin tmr_load = 1'b1; tmr_val = CNT_W'(GAP_CYC - 1); end
      PH_GAP:   ;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= reject;
      unique case (ph)
        PH_IDLE: if (accept) begin
          ph     <= PH_LEAD;
          busy_q <= 1'b1;
        end
        PH_LEAD: if (tmr_zero) begin
          ph     <= PH_HIGH;
          sclk_q <= 1'b1;
        end
        PH_HIGH: if (tmr_zero) begin
          sclk_q <= 1'b0;
          ph     <= last_bit ? PH_TRAIL : PH_LOW;
        end
        PH_LOW: if (tmr_zero) begin
          sclk_q <= 1'b1;
          ph     <= PH_HIGH;
        end
        PH_TRAIL: if (tmr_zero) begin
          done_q <= 1'b1;
          ph     <= PH_GAP;
        end
        PH_GAP: if (tmr_zero) begin
          busy_q <= 1'b0;
          ph     <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  dtcp_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  dtcp_shift_out #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .word     (pack_word(req_stby, req_state)),
    .shift    (do_shift),
    .bit_out  (sdata),
    .last_bit (last_bit)
  );

  dtcp_sel_decode #(.NUM_SLV(NUM_SLV), .IDX_W(IDX_W)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .idx    (req_idx),
    .set    (accept),
    .clr    (sel_clr),
    .idx_ok (idx_ok),
    .sel    (sen)
  );

  assign sclk = sclk_q;
  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  // R4: data is frozen while the serial clock is high
  p_data_still_r4: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata));
  // R6: serial clock only toggles inside an enable window
  p_sclk_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (sen == '0) |-> !sclk);
  // R8: busy covers every cycle an enable is driven
  p_busy_cover_r8: assert property (@(posedge clk) disable iff (rst)
    (sen != '0) |-> busy);
  // R7: done only in the cycle right after an enable fell
  p_done_edge_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ((sen == '0) && ($past(sen) != '0)));
  // R9: rejected request leaves the link idle
  p_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> ((sen == '0) && !busy));
endmodule

// File: tb/dtc_prog_master_bench.sv
module dtc_prog_master_bench;
  localparam int  NUM_SLV = 4;
  localparam int  IDX_W   = 3;
  localparam longint CLK_PS = 20000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic [IDX_W-1:0]   req_idx = '0;
  logic [4:0]         req_state = '0;
  logic               req_stby = 1'b0;
  logic               busy, done, err, sclk, sdata;
  logic [NUM_SLV-1:0] sen;

  always #10 clk = ~clk;

  dtc_prog_master #(.NUM_SLV(NUM_SLV), .IDX_W(IDX_W)) u_dtc_prog_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .req_state(req_state), .req_stby(req_stby), .busy(busy), .done(done),
    .err(err), .sclk(sclk), .sdata(sdata), .sen(sen)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state
  int unsigned exp_idx = 0;
  logic [7:0]  exp_word = '0;
  longint cyc = 0, t_sen_rise = 0, t_sen_fall = 0, t_rise = 0, t_fall = 0;
  int bits = 0, ntrans = 0;
  logic [7:0] cap = '0;
  logic p_sclk = 0, p_sdata = 0, p_busy = 0;
  logic [NUM_SLV-1:0] p_sen = '0;
  bit mon_on = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (sen != '0 && p_sen == '0) begin
        chk(sen == (NUM_SLV'(1) << exp_idx), "R3 enable select", sen, NUM_SLV'(1) << exp_idx);
        if (ntrans > 0)
          chk((cyc - t_sen_fall) * CLK_PS >= 38400, "R10 enable gap", (cyc - t_sen_fall) * CLK_PS, 38400);
        t_sen_rise = cyc; bits = 0; cap = '0;
      end
      if (sclk && sdata != p_sdata)
        chk(0, "R4 data moved with clock high", sdata, p_sdata);
      if (sclk && !p_sclk) begin
        if (bits == 0) begin
          chk((cyc - t_sen_rise) * CLK_PS >= 19200, "R6 enable lead", (cyc - t_sen_rise) * CLK_PS, 19200);
        end else begin
          chk((cyc - t_fall) * CLK_PS >= 13200, "R5 low phase", (cyc - t_fall) * CLK_PS, 13200);
          chk((cyc - t_rise) * CLK_PS >= 38462, "R5 clock period", (cyc - t_rise) * CLK_PS, 38462);
        end
        cap = {cap[6:0], sdata};
        bits++;
        t_rise = cyc;
      end
      if (!sclk && p_sclk) begin
        chk((cyc - t_rise) * CLK_PS >= 13200, "R5 high phase", (cyc - t_rise) * CLK_PS, 13200);
        t_fall = cyc;
      end
      if (sen == '0 && p_sen != '0) begin
        chk(bits == 8, "R2 bit count", bits, 8);
        chk(cap == exp_word, "R2 word", cap, exp_word);
        chk(done == 1'b1, "R7 done at enable fall", done, 1);
        chk((cyc - t_rise) * CLK_PS >= 19200, "R6 enable hold", (cyc - t_rise) * CLK_PS, 19200);
        chk(sclk == 1'b0, "R6 clock low at enable fall", sclk, 0);
        t_sen_fall = cyc;
        ntrans++;
      end else if (done) begin
        chk(0, "R7 stray done", done, 0);
      end
      if (!busy && p_busy)
        chk((cyc - t_sen_fall) * CLK_PS >= 38400, "R8 busy tail", (cyc - t_sen_fall) * CLK_PS, 38400);
      p_sclk = sclk; p_sdata = sdata; p_sen = sen; p_busy = busy;
    end
  end

  task automatic send(input int idx, input logic [4:0] st, input logic sb, input bit stray);
    while (busy) @(negedge clk);
    exp_idx = idx;
    exp_word = {2'b00, sb, st};
    req_idx = IDX_W'(idx); req_state = st; req_stby = sb; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    chk(sen == (NUM_SLV'(1) << idx), "R3 enable after accept", sen, NUM_SLV'(1) << idx);
    if (stray) begin
      repeat (4) @(negedge clk);
      req_idx = IDX_W'((idx + 1) % NUM_SLV); req_state = ~st; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(sen == (NUM_SLV'(1) << idx), "R8 request while busy ignored", sen, NUM_SLV'(1) << idx);
    end
    while (busy) @(negedge clk);
    if (stray) begin
      repeat (4) @(negedge clk);
      chk(sen == '0, "R8 no follow-up transfer", sen, 0);
      chk(busy == 1'b0, "R8 stays idle", busy, 0);
    end
  endtask

  task automatic send_bad(input int idx);
    while (busy) @(negedge clk);
    req_idx = IDX_W'(idx); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R9 error pulse", err, 1);
    chk(sen == '0, "R9 no enable", sen, 0);
    chk(busy == 1'b0, "R9 not busy", busy, 0);
    @(negedge clk);
    chk(err == 1'b0, "R9 error one cycle", err, 0);
    chk(sen == '0, "R9 still no enable", sen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({sclk, busy, done, err} == 4'b0 && sen == '0, "R1 state in reset", {sclk, busy, done, err, sen}, 0);
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1;
    chk({sclk, busy, done, err} == 4'b0 && sen == '0, "R1 state after reset", {sclk, busy, done, err, sen}, 0);
    for (int i = 0; i < NUM_SLV; i++)
      for (int sb = 0; sb < 2; sb++)
        for (int s = 0; s < 32; s++)
          send(i, 5'(s), 1'(sb), 1'b0);
    send(2, 5'h15, 1'b1, 1'b1);
    for (int b = NUM_SLV; b < (1 << IDX_W); b++) send_bad(b);
    send(0, 5'h1f, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(ntrans == NUM_SLV * 64 + 2, "R2 transfer count", ntrans, NUM_SLV * 64 + 2);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule